// File: doc/BRIEF.md
# Nibble-Wide BCD Real-Time Clock

This block is a time-of-day and calendar counter for a host that talks to it through sixteen 4-bit locations. Every time field is kept as packed BCD digits, so the host reads and writes decimal digits directly. The time fields are tenths of a second, seconds, minutes, hours, day of month, month, two-digit year and day of week. A 32.768 kHz enable pulse feeds an internal divider that makes the 0.1 s step. The calendar handles month lengths, and a 2-bit leap counter decides whether February has 29 days.

Location 0 is the control and status word. Writing it stops or starts the clock, turns on a fast-count test mode, gates the periodic interrupt, and chooses what location 15 means: either the clock-setting register (12/24-hour mode and the leap counter) or the interrupt register. Reading it returns a flag that shows whether the time changed since the last read, and the same read clears that flag and acknowledges the interrupt. The host sets the time like this: stop the clock, write the digits, then restart the clock.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the clock is running in 24-hour mode at 00:00:00.0 on day 01, month 01, year 00, weekday 1, with the leap counter at 0. The irq output is low, the change flag is clear, and location 15 selects the setting register.
- R2: While running, the tenths digit advances once every DIV pulses of tick_in. When control bit 3 (test mode) is 1, it advances on every tick_in pulse instead.
- R3: Reads return the digit at each address, and rdata is valid on the cycle after rd_en. The map is: 1 tenths, 2/3 seconds units/tens, 4/5 minutes, 6/7 hours, 8/9 day, 10/11 month, 12/13 year, 14 weekday (1..7).
- R4: Time rolls over from tenths 9 to seconds, from second 59 to minutes, and from minute 59 to hours. In 24-hour mode, hour 23 rolls to 00 and the day advances.
- R5: In 12-hour mode (setting bit 0 = 0), the hours tens digit carries PM in bit 1 and the tens digit in bit 0. The sequence runs 11 AM to 12 PM, then 12 to 01, and 11 PM to 12 AM with the day advancing.
- R6: The day after the last day of a month is day 01 of the next month. April, June, September and November have 30 days. February has 29 days when the leap counter is 0, and 28 days otherwise.
- R7: After December 31 the date becomes January 01, the year advances modulo 100 (99 becomes 00), and the leap counter advances modulo 4. The weekday advances each day and wraps from 7 to 1.
- R8: Reading location 0 returns the change flag in bit 3, with the other bits 0, and then clears the flag. The flag is set on every tenths step, and a step wins over a clearing read in the same cycle.
- R9: Control bit 2 = 1 stops the clock and holds the divider at zero, so the first step after a restart comes a full DIV pulses later. Writes to locations 1..14 take effect only while the clock is stopped. Location 1 is never loaded from the data, and any write to locations 1..14 while stopped sets tenths to 0.
- R10: Control bit 1 selects location 15. When it is 0, location 15 is the setting register, with bit 0 for 24-hour mode, bits 3:2 for the leap counter, and bit 1 reading 0. When it is 1, location 15 is the interrupt register.
- R11: Interrupt register bits 2:0 pick the period: 0 none, 1 0.1 s, 2 0.5 s, 3 1 s, 4 5 s, 5 10 s, 6 30 s, 7 60 s. Bit 3 = 1 makes the interrupt single-shot and 0 makes it repeat. The irq output stays high until location 0 is read.
- R12: Control bit 0 = 1 holds irq low and holds the interval count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | 32.768 kHz enable pulse, one clk wide |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register location |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |
| irq | output | 1 | Periodic interrupt, held until location 0 is read |

## Verification
The range assertions assume that the host writes time digits only while the clock is stopped, and that the digits hold a valid BCD date and time by the time the clock restarts. For that reason the range checks apply only while the clock is running, and they ignore the partial values that appear between single-digit writes. The random stimulus only ever loads legal dates: the day is drawn within the month's length for the chosen leap counter. It also biases the time fields toward their upper limits, so that the day, month and year rollovers occur often in both hour modes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 4;
  localparam int IRQ_CNT_W = 10;

  typedef logic [7:0] bcd8_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'd0, A_TENTH, A_SEC_U, A_SEC_T, A_MIN_U, A_MIN_T,
    A_HR_U, A_HR_T, A_DAY_U, A_DAY_T, A_MON_U, A_MON_T,
    A_YR_U, A_YR_T, A_WDAY, A_CFG
  } reg_addr_e;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd8_t month_len(bcd8_t mon, logic [1:0] leap);
    case (mon)
      8'h02:                      return (leap == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [IRQ_CNT_W-1:0] irq_period(logic [2:0] code);
    case (code)
      3'd1:    return IRQ_CNT_W'(1);
      3'd2:    return IRQ_CNT_W'(5);
      3'd3:    return IRQ_CNT_W'(10);
      3'd4:    return IRQ_CNT_W'(50);
      3'd5:    return IRQ_CNT_W'(100);
      3'd6:    return IRQ_CNT_W'(300);
      3'd7:    return IRQ_CNT_W'(600);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 3277
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic bypass,
  input  logic tick_in,
  output logic tenth
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(DIV - 1));
  assign tenth  = tick_in && !hold && (at_end || bypass);

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (tick_in) cnt <= (at_end || bypass) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             time_wr,
  input  logic             set_wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0] wdata,
  output logic [NIB_W-1:0] tenths,
  output bcd8_t            sec,
  output bcd8_t            min,
  output bcd8_t            hr,
  output bcd8_t            day,
  output bcd8_t            mon,
  output bcd8_t            yr,
  output logic [2:0]       wday,
  output logic [1:0]       leap,
  output logic             mode24
);
  bcd8_t hr_next, h12, h_inc;
  logic  day_roll;

  always_comb begin
    h12   = {3'b000, hr[4:0]};
    h_inc = bcd_inc(h12);
    if (mode24) begin
      day_roll = (hr >= 8'h23);
      hr_next  = day_roll ? 8'h00 : bcd_inc(hr);
    end else begin
      day_roll = hr[5] && (h12 == 8'h11);
      if (h12 == 8'h11)      hr_next = {2'b00, ~hr[5], 5'h12};
      else if (h12 >= 8'h12) hr_next = {2'b00, hr[5], 5'h01};
      else                   hr_next = {2'b00, hr[5], h_inc[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tenths <= '0;  sec <= '0;  min <= '0;  hr <= '0;
      day <= 8'h01;  mon <= 8'h01;  yr <= '0;
      wday <= 3'd1;  leap <= 2'd0;  mode24 <= 1'b1;
    end else begin
      if (set_wr) begin
        mode24 <= wdata[0];
        leap   <= wdata[3:2];
      end
      if (time_wr) begin
        tenths <= '0;
        case (reg_addr_e'(waddr))
          A_SEC_U: sec[3:0] <= wdata;
          A_SEC_T: sec[7:4] <= wdata;
          A_MIN_U: min[3:0] <= wdata;
          A_MIN_T: min[7:4] <= wdata;
          A_HR_U:  hr[3:0]  <= wdata;
          A_HR_T:  hr[7:4]  <= wdata;
          A_DAY_U: day[3:0] <= wdata;
          A_DAY_T: day[7:4] <= wdata;
          A_MON_U: mon[3:0] <= wdata;
          A_MON_T: mon[7:4] <= wdata;
          A_YR_U:  yr[3:0]  <= wdata;
          A_YR_T:  yr[7:4]  <= wdata;
          A_WDAY:  wday     <= wdata[2:0];
          default: ;
        endcase
      end else if (adv) begin
        if (tenths < 4'd9) tenths <= tenths + 4'd1;
        else begin
          tenths <= '0;
          if (sec < 8'h59) sec <= bcd_inc(sec);
          else begin
            sec <= '0;
            if (min < 8'h59) min <= bcd_inc(min);
            else begin
              min <= '0;
              hr  <= hr_next;
              if (day_roll) begin
                wday <= (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
                if (day >= month_len(mon, leap)) begin
                  day <= 8'h01;
                  if (mon >= 8'h12) begin
                    mon  <= 8'h01;
                    yr   <= (yr >= 8'h99) ? 8'h00 : bcd_inc(yr);
                    leap <= leap + 2'd1;
                  end else begin
                    mon <= bcd_inc(mon);
                  end
                end else begin
                  day <= bcd_inc(day);
                end
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_irq_timer.sv
module rtc_irq_timer
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             cfg_wr,
  input  logic [NIB_W-1:0] wdata,
  input  logic             ack,
  output logic [NIB_W-1:0] cfg,
  output logic             irq
);
  logic [IRQ_CNT_W-1:0] cnt, period;
  logic                 armed;

  assign period = irq_period(cfg[2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;  cnt <= '0;  armed <= 1'b1;  irq <= 1'b0;
    end else begin
      if (ack) irq <= 1'b0;
      if (cfg_wr) begin
        cfg   <= wdata;
        cnt   <= '0;
        armed <= 1'b1;
      end else if (halt) begin
        cnt <= '0;
      end else if (tick && armed && period != '0) begin
        if (cnt + 1'b1 >= period) begin
          cnt <= '0;
          irq <= 1'b1;
          if (cfg[3]) armed <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (halt) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import rtc_pkg::*;
#(
  parameter int DIV = 3277
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_in,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [3:0]  wdata,
  output logic [3:0]  rdata,
  output logic        irq
);
  logic ctrl_test, ctrl_stop, ctrl_sel, ctrl_istop, chg_flag, tenth;
  logic wr_ctrl, rd_ctrl, time_wr, set_wr, irq_wr;
  logic [NIB_W-1:0] tenths, irq_cfg, rd_mux;
  bcd8_t sec, min, hr, day, mon, yr;
  logic [2:0] wday;
  logic [1:0] leap;
  logic mode24;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign rd_ctrl = rd_en && (addr == A_CTRL);
  assign time_wr = wr_en && ctrl_stop && (addr != A_CTRL) && (addr != A_CFG);
  assign set_wr  = wr_en && (addr == A_CFG) && !ctrl_sel;
  assign irq_wr  = wr_en && (addr == A_CFG) && ctrl_sel;

  rtc_prescaler #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .hold(ctrl_stop), .bypass(ctrl_test),
    .tick_in(tick_in), .tenth(tenth)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .adv(tenth), .time_wr(time_wr), .set_wr(set_wr),
    .waddr(addr), .wdata(wdata), .tenths(tenths), .sec(sec), .min(min),
    .hr(hr), .day(day), .mon(mon), .yr(yr), .wday(wday), .leap(leap),
    .mode24(mode24)
  );

  rtc_irq_timer u_irq (
    .clk(clk), .rst(rst), .tick(tenth), .halt(ctrl_istop), .cfg_wr(irq_wr),
    .wdata(wdata), .ack(rd_ctrl), .cfg(irq_cfg), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      {ctrl_test, ctrl_stop, ctrl_sel, ctrl_istop} <= 4'b0000;
      chg_flag <= 1'b0;
    end else begin
      if (wr_ctrl) {ctrl_test, ctrl_stop, ctrl_sel, ctrl_istop} <= wdata;
      if (tenth)        chg_flag <= 1'b1;
      else if (rd_ctrl) chg_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_CTRL:  rd_mux = {chg_flag, 3'b000};
      A_TENTH: rd_mux = tenths;
      A_SEC_U: rd_mux = sec[3:0];
      A_SEC_T: rd_mux = sec[7:4];
      A_MIN_U: rd_mux = min[3:0];
      A_MIN_T: rd_mux = min[7:4];
      A_HR_U:  rd_mux = hr[3:0];
      A_HR_T:  rd_mux = hr[7:4];
      A_DAY_U: rd_mux = day[3:0];
      A_DAY_T: rd_mux = day[7:4];
      A_MON_U: rd_mux = mon[3:0];
      A_MON_T: rd_mux = mon[7:4];
      A_YR_U:  rd_mux = yr[3:0];
      A_YR_T:  rd_mux = yr[7:4];
      A_WDAY:  rd_mux = {1'b0, wday};
      default: rd_mux = ctrl_sel ? irq_cfg : {leap, 1'b0, mode24};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic       irq,
  input logic       running,
  input logic       irq_halt,
  input logic [3:0] tenths,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hr,
  input logic [7:0] day,
  input logic [7:0] mon,
  input logic [7:0] yr,
  input logic [2:0] wday
);
  a_r2_tenths_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(tenths) |-> (tenths == $past(tenths) + 4'd1) || (tenths == 4'd0));

  a_r4_clock_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (sec <= 8'h59 && min <= 8'h59 && sec[3:0] <= 4'd9 && min[3:0] <= 4'd9));

  a_r6_date_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (day >= 8'h01 && day <= 8'h31 && mon >= 8'h01 && mon <= 8'h12));

  a_r7_wday_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (wday >= 3'd1 && wday <= 3'd7));

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (!running && !wr_en) |=> $stable({tenths, sec, min, hr, day, mon, yr}));

  a_r11_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_en && !(rd_en && addr == 4'd0)) |=> irq);

  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_halt && !wr_en) |=> !irq);
endmodule

bind nibble_rtc rtc_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .irq(irq),
  .running(!ctrl_stop), .irq_halt(ctrl_istop), .tenths(tenths), .sec(sec),
  .min(min), .hr(hr), .day(day), .mon(mon), .yr(yr), .wday(wday)
);

// File: tb/nibble_rtc_test.sv
module nibble_rtc_test;
  localparam int DIV = 3;

  logic clk = 1'b0, rst = 1'b1, tick_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0, wdata = '0, rdata;
  logic irq;
  int tests = 0, fails = 0;

  int m_tenth, m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd, m_lc;
  bit m24;

  always #5 clk = ~clk;

  nibble_rtc #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  function automatic int mlen(int mon, int lc);
    if (mon == 2) return (lc == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_tenth++;
    if (m_tenth < 10) return;
    m_tenth = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_day++;
    if (m_day <= mlen(m_mon, m_lc)) return;
    m_day = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1;
    m_yr = (m_yr + 1) % 100;
    m_lc = (m_lc + 1) % 4;
  endtask

  task automatic run_tenths(int n);
    ticks(n * DIV);
    for (int i = 0; i < n; i++) model_step();
  endtask

  function automatic logic [3:0] exp_nib(int a);
    int h12;
    logic pm;
    h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
    pm  = (m_hr >= 12);
    case (a)
      1:  return 4'(m_tenth);
      2:  return 4'(m_sec % 10);
      3:  return 4'(m_sec / 10);
      4:  return 4'(m_min % 10);
      5:  return 4'(m_min / 10);
      6:  return m24 ? 4'(m_hr % 10) : 4'(h12 % 10);
      7:  return m24 ? 4'(m_hr / 10) : {2'b00, pm, (h12 >= 10)};
      8:  return 4'(m_day % 10);
      9:  return 4'(m_day / 10);
      10: return 4'(m_mon % 10);
      11: return 4'(m_mon / 10);
      12: return 4'(m_yr % 10);
      13: return 4'(m_yr / 10);
      14: return 4'(m_wd);
      default: return {2'(m_lc), 1'b0, m24};
    endcase
  endfunction

  task automatic check_all(string tag);
    logic [3:0] d;
    for (int a = 1; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("%s addr %0d", tag, a), d, exp_nib(a));
    end
  endtask

  // expects the clock stopped and location 15 on the setting register
  task automatic load_model();
    wr(4'd15, {2'(m_lc), 1'b0, m24});
    for (int a = 2; a < 15; a++) wr(4'(a), exp_nib(a));
    m_tenth = 0;
  endtask

  task automatic set_and_roll(string tag, int hr, int day, int mon, int yr, int wd, int lc, bit mode);
    wr(4'd0, 4'b0100);
    m_hr = hr; m_min = 59; m_sec = 59; m_day = day; m_mon = mon; m_yr = yr;
    m_wd = wd; m_lc = lc; m24 = mode;
    load_model();
    wr(4'd0, 4'b0000);
    run_tenths(10);
    check_all(tag);
  endtask

  initial begin
    logic [3:0] d;
    int seed;
    seed = $urandom(32'd4242);
    m_tenth = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1;
    m_yr = 0; m_wd = 1; m_lc = 0; m24 = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", irq, 0);
    check_all("R1");
    rd(4'd0, d); chk("R1 flag", d, 0);

    // R2: divider length and test mode
    ticks(DIV - 1);
    rd(4'd1, d); chk("R2 before full count", d, 0);
    ticks(1); m_tenth = 1;
    rd(4'd1, d); chk("R2 after DIV ticks", d, 1);
    wr(4'd0, 4'b1000);
    ticks(1); m_tenth = 2;
    rd(4'd1, d); chk("R2 test mode", d, 2);
    wr(4'd0, 4'b0000);

    // R8: change flag read-to-clear
    rd(4'd0, d); chk("R8 flag set", d, 8);
    rd(4'd0, d); chk("R8 flag cleared", d, 0);

    // R9: writes ignored while running, accepted while stopped
    wr(4'd2, 4'd5);
    rd(4'd2, d); chk("R9 running write ignored", d, 0);
    wr(4'd0, 4'b0100);
    wr(4'd1, 4'd7); m_tenth = 0;
    rd(4'd1, d); chk("R9 tenths read-only and zeroed", d, 0);
    wr(4'd2, 4'd5); m_sec = 5;
    rd(4'd2, d); chk("R9 stopped write", d, 5);
    wr(4'd0, 4'b0000);
    ticks(DIV - 1);
    wr(4'd0, 4'b0100);
    wr(4'd0, 4'b0000);
    ticks(DIV - 1);
    rd(4'd1, d); chk("R9 divider restarted", d, 0);
    ticks(1); m_tenth = 1;
    rd(4'd1, d); chk("R9 full tenth after restart", d, 1);
    wr(4'd0, 4'b0100);
    ticks(3 * DIV);
    rd(4'd1, d); chk("R9 stopped holds", d, 1);
    wr(4'd0, 4'b0000);

    // R4, R5, R6, R7: directed rollovers
    set_and_roll("R4 hour", 12, 10, 5, 20, 3, 0, 1'b1);
    set_and_roll("R4 midnight", 23, 10, 5, 20, 3, 0, 1'b1);
    set_and_roll("R7 new year", 23, 31, 12, 99, 7, 3, 1'b1);
    set_and_roll("R6 feb leap", 23, 28, 2, 24, 2, 0, 1'b1);
    set_and_roll("R6 feb common", 23, 28, 2, 25, 2, 1, 1'b1);
    set_and_roll("R6 april", 23, 30, 4, 25, 5, 1, 1'b1);
    set_and_roll("R5 pm to am", 23, 15, 6, 30, 4, 2, 1'b0);
    set_and_roll("R5 am to pm", 11, 15, 6, 30, 4, 2, 1'b0);
    set_and_roll("R5 twelve to one", 12, 15, 6, 30, 4, 2, 1'b0);

    // R3: random legal dates in both hour modes
    for (int it = 0; it < 40; it++) begin
      wr(4'd0, 4'b0100);
      m24   = $urandom % 2;
      m_lc  = $urandom % 4;
      m_mon = 1 + $urandom % 12;
      m_yr  = $urandom % 100;
      m_wd  = 1 + $urandom % 7;
      if ($urandom % 2) begin
        m_day = mlen(m_mon, m_lc); m_hr = 23; m_min = 59; m_sec = 50 + $urandom % 10;
        if ($urandom % 2) m_mon = 12;
        if (m_day > mlen(m_mon, m_lc)) m_day = mlen(m_mon, m_lc);
      end else begin
        m_day = 1 + $urandom % mlen(m_mon, m_lc);
        m_hr = $urandom % 24; m_min = $urandom % 60; m_sec = $urandom % 60;
      end
      load_model();
      wr(4'd0, 4'b0000);
      run_tenths(1 + $urandom % 300);
      check_all("R3 random");
    end

    // R10: location 15 selection
    wr(4'd0, 4'b0010);
    rd(4'd15, d); chk("R10 irq reg reset", d, 0);
    wr(4'd15, 4'b0001);
    rd(4'd15, d); chk("R10 irq reg readback", d, 1);
    wr(4'd0, 4'b0000);
    rd(4'd15, d); chk("R10 setting reg kept", d, exp_nib(15));
    wr(4'd0, 4'b0010);

    // R11: repeating and single-shot interrupt
    rd(4'd0, d);
    run_tenths(1);
    chk("R11 repeat fires", irq, 1);
    run_tenths(2);
    chk("R11 held until read", irq, 1);
    rd(4'd0, d);
    chk("R11 cleared by read", irq, 0);
    run_tenths(1);
    chk("R11 repeats", irq, 1);
    wr(4'd15, 4'b1010);
    rd(4'd0, d);
    run_tenths(4);
    chk("R11 single early", irq, 0);
    run_tenths(1);
    chk("R11 single at 0.5 s", irq, 1);
    rd(4'd0, d);
    run_tenths(10);
    chk("R11 single no repeat", irq, 0);

    // R12: interrupt gate
    wr(4'd0, 4'b0011);
    wr(4'd15, 4'b0001);
    run_tenths(3);
    chk("R12 gated", irq, 0);
    wr(4'd0, 4'b0010);
    run_tenths(1);
    chk("R12 resumes", irq, 1);
    rd(4'd0, d);
    wr(4'd0, 4'b0000);
    check_all("R4 final");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule